// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is the station-management master used to reach PHY registers over a two-wire management bus. Software places a complete clause-22 frame, packed into one 32-bit command word, into the data register. The block then clocks out a preamble of ones followed by the 32 command bits, most significant bit first, on a management clock derived from the system clock. For a read it lets go of the data line across the turnaround and data bits, gathers the sixteen bits the PHY returns and folds them into the low half of the same data register.

Completion is reported through a one-bit management event, bit 23 of the event word, which stays set until software writes a one to that bit position. The management clock speed comes from a speed register: software writes the ceiling of the system clock over 5 MHz, shifted left by one, so the half period in system clocks equals that value, which holds the management clock at or below 2.5 MHz.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset mdc is 0, mdioOe is 0, dataWord is 0 and evtWord is 0.
- R2: Each frame starts with 32 bit periods in which mdioOe is 1 and mdioOut is 1.
- R3: After the preamble the 32 bits of the command word are driven most significant bit first, one per mdc period, changing only at the falling edge of mdc, for 64 mdc rising edges in all.
- R4: The mdc half period is the speed register value with bit 0 taken as zero, in system clocks; a value of 0 or 1 gives a half period of 2 clocks; mdc is 0 whenever no frame is running.
- R5: A command whose bits 29:28 are 2'b10 is a read: mdioOe is 0 from the bit period of command bit 17 to the end of the frame, mdioIn is sampled at each rising mdc of command bits 15..0, and at the end dataWord holds the command's bits 31:16 above the sixteen sampled bits (first sampled bit in bit 15).
- R6: A command with any other value in bits 29:28 is a write: mdioOe stays 1 for all 64 bits and dataWord keeps the command word unchanged.
- R7: The event bit (evtWord bit 23) becomes 1 after the system clock edge that ends the 128th mdc half period counted from the edge that accepted the command, and not earlier.
- R8: An event-register write with bit 23 set clears the event bit; a write with bit 23 clear leaves it as it is; when such a clear falls on the same edge as a frame completion, the event bit ends up set.
- R9: A command write while a frame is in progress has no effect on the frame on the wire, its timing or dataWord.
- R10: All evtWord bits other than bit 23 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdWrEn | input | 1 | Write strobe for the data register; starts a frame when idle |
| cmdWrData | input | 32 | Packed command word |
| dataWord | output | 32 | Data register contents |
| evtWrEn | input | 1 | Write strobe for the event register |
| evtWrData | input | 32 | Write-one-to-clear data for the event register |
| evtWord | output | 32 | Event register, bit 23 is the completion event |
| speedWrEn | input | 1 | Write strobe for the speed register |
| speedWrData | input | 7 | Speed value, half period of mdc in clocks (bit 0 ignored) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data line value driven by the block |
| mdioOe | output | 1 | Data line drive enable |
| mdioIn | input | 1 | Data line value seen at the pin |

## Verification
The event bit can be set by a completing frame and cleared by a software write on the same clock edge. The bench computes the completing edge as 128 half periods after the accepting edge, drops the write-one-to-clear onto exactly that edge and expects the bit to read as set afterwards, then clears it with a separate write. A command written into a running frame is the other overlap: the bench injects one mid-frame and judges the wire bits, the completion timing and the data register against the first command alone.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int CMD_W      = 32;
  localparam int PRE_LEN    = 32;
  localparam int FRAME_LEN  = PRE_LEN + CMD_W;
  localparam int CNT_W      = $clog2(FRAME_LEN);
  localparam int RD_W       = 16;
  // bit period index where the turnaround of a read begins (command bit 17)
  localparam int TA_FIRST   = PRE_LEN + CMD_W - 18;
  localparam int DATA_FIRST = PRE_LEN + CMD_W - RD_W;
  localparam int OP_HI      = 29;
  localparam int OP_LO      = 28;
  localparam logic [1:0] OP_READ = 2'b10;
  localparam int EVT_BIT    = 23;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_CMD  = 2'd2
  } mgmtState_t;

  typedef struct packed {
    logic load;     // accept command word
    logic shift;    // advance outgoing bit (mdc falling)
    logic capture;  // take one read data bit (mdc rising)
    logic finish;   // frame complete
  } mgmtStrb_t;
endpackage

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int SPEED_W = 7,
  parameter logic [SPEED_W-1:0] SPEED_RST = SPEED_W'(20)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdWrEn,
  input  logic                speedWrEn,
  input  logic [SPEED_W-1:0]  speedWrData,
  input  logic                opRead,
  output logic                mdc,
  output logic                mdioOe,
  output logic                busy,
  output logic [CNT_W-1:0]    bitCnt,
  output mgmtStrb_t           strb
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_LEN - 1);
  localparam logic [CNT_W-1:0] TA_IDX   = CNT_W'(TA_FIRST);
  localparam logic [CNT_W-1:0] DAT_IDX  = CNT_W'(DATA_FIRST);

  mgmtState_t         state;
  logic [SPEED_W-1:0] speedReg;
  logic [SPEED_W-1:0] divCnt;
  logic [SPEED_W-1:0] halfLen;
  logic [SPEED_W-1:0] halfEff;
  logic               mdcQ;
  logic               halfEnd;
  logic               riseNow;
  logic               fallNow;

  always_comb begin
    halfLen = {speedReg[SPEED_W-1:1], 1'b0};
    halfEff = (halfLen == '0) ? SPEED_W'(2) : halfLen;
  end

  assign busy    = (state != ST_IDLE);
  assign halfEnd = (divCnt >= halfEff - SPEED_W'(1));
  assign riseNow = busy && halfEnd && !mdcQ;
  assign fallNow = busy && halfEnd && mdcQ;
  assign mdc     = mdcQ;
  assign mdioOe  = busy && !(opRead && (bitCnt >= TA_IDX));

  always_comb begin
    strb.load    = (state == ST_IDLE) && cmdWrEn;
    strb.shift   = fallNow;
    strb.capture = riseNow && opRead && (bitCnt >= DAT_IDX);
    strb.finish  = fallNow && (bitCnt == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      divCnt   <= '0;
      mdcQ     <= 1'b0;
      speedReg <= SPEED_RST;
    end else begin
      if (speedWrEn) speedReg <= speedWrData;
      if (state == ST_IDLE) begin
        if (cmdWrEn) begin
          state  <= ST_PRE;
          bitCnt <= '0;
          divCnt <= '0;
          mdcQ   <= 1'b0;
        end
      end else if (halfEnd) begin
        divCnt <= '0;
        mdcQ   <= ~mdcQ;
        if (mdcQ) begin
          if (bitCnt == LAST_BIT) begin
            state  <= ST_IDLE;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + CNT_W'(1);
            if (bitCnt == PRE_LAST) state <= ST_CMD;
          end
        end
      end else begin
        divCnt <= divCnt + SPEED_W'(1);
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_dpath.sv
module mdio_mgmt_dpath
  import mdio_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  mgmtStrb_t        strb,
  input  logic [CMD_W-1:0] cmdWrData,
  input  logic             evtWrEn,
  input  logic [31:0]      evtWrData,
  input  logic             mdioIn,
  output logic             mdioOut,
  output logic             opRead,
  output logic [CMD_W-1:0] dataReg,
  output logic [31:0]      evtWord
);
  logic [FRAME_LEN-1:0] txSh;
  logic [RD_W-1:0]      rxSh;
  logic                 evtFlag;

  assign mdioOut = txSh[FRAME_LEN-1];
  assign opRead  = (dataReg[OP_HI:OP_LO] == OP_READ);
  assign evtWord = 32'(evtFlag) << EVT_BIT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh    <= '0;
      rxSh    <= '0;
      dataReg <= '0;
    end else if (strb.load) begin
      txSh    <= {{PRE_LEN{1'b1}}, cmdWrData};
      rxSh    <= '0;
      dataReg <= cmdWrData;
    end else begin
      if (strb.shift)   txSh <= {txSh[FRAME_LEN-2:0], 1'b0};
      if (strb.capture) rxSh <= {rxSh[RD_W-2:0], mdioIn};
      if (strb.finish && opRead) dataReg[RD_W-1:0] <= rxSh;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                evtFlag <= 1'b0;
    else if (strb.finish)                     evtFlag <= 1'b1;
    else if (evtWrEn && evtWrData[EVT_BIT])   evtFlag <= 1'b0;
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int SPEED_W = 7,
  parameter logic [SPEED_W-1:0] SPEED_RST = SPEED_W'(20)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdWrEn,
  input  logic [31:0]        cmdWrData,
  output logic [31:0]        dataWord,
  input  logic               evtWrEn,
  input  logic [31:0]        evtWrData,
  output logic [31:0]        evtWord,
  input  logic               speedWrEn,
  input  logic [SPEED_W-1:0] speedWrData,
  output logic               mdc,
  output logic               mdioOut,
  output logic               mdioOe,
  input  logic               mdioIn
);
  mgmtStrb_t        strb;
  logic             opRead;
  logic             busy;
  logic [CNT_W-1:0] bitCnt;
  logic             finishS;

  assign finishS = strb.finish;

  mdio_mgmt_ctrl #(.SPEED_W(SPEED_W), .SPEED_RST(SPEED_RST)) u_ctl (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn),
    .speedWrEn(speedWrEn), .speedWrData(speedWrData), .opRead(opRead),
    .mdc(mdc), .mdioOe(mdioOe), .busy(busy), .bitCnt(bitCnt), .strb(strb)
  );

  mdio_mgmt_dpath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdWrData(cmdWrData),
    .evtWrEn(evtWrEn), .evtWrData(evtWrData), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .opRead(opRead), .dataReg(dataWord), .evtWord(evtWord)
  );
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker
  import mdio_mgmt_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             mdc,
  input logic             mdioOut,
  input logic             mdioOe,
  input logic             cmdWrEn,
  input logic             evtWrEn,
  input logic [31:0]      evtWrData,
  input logic [31:0]      dataWord,
  input logic [31:0]      evtWord,
  input logic             busy,
  input logic [CNT_W-1:0] bitCnt,
  input logic             finishS,
  input logic             opRead
);
  AST_MDIO_HELD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc)) |-> ($stable(mdioOut) && $stable(mdioOe))); // R3
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc); // R4
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && opRead && (bitCnt >= CNT_W'(TA_FIRST))) |-> !mdioOe); // R5
  AST_EVT_SET: assert property (@(posedge clk) disable iff (!rstN)
    finishS |=> evtWord[EVT_BIT]); // R7
  AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (evtWrEn && evtWrData[EVT_BIT] && !finishS) |=> !evtWord[EVT_BIT]); // R8
  AST_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdWrEn && !finishS) |=> $stable(dataWord)); // R9
  AST_EVT_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $countones(evtWord) <= 1 && (evtWord & ~(32'h1 << EVT_BIT)) == 32'h0); // R10
endmodule

bind mdio_mgmt_master mdio_mgmt_checker u_chk (
  .clk(clk), .rstN(rstN), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
  .cmdWrEn(cmdWrEn), .evtWrEn(evtWrEn), .evtWrData(evtWrData),
  .dataWord(dataWord), .evtWord(evtWord), .busy(busy), .bitCnt(bitCnt),
  .finishS(finishS), .opRead(opRead)
);

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EVT_MASK = 32'h0080_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWrEn = 1'b0;
  logic [31:0] cmdWrData = '0;
  logic [31:0] dataWord;
  logic        evtWrEn = 1'b0;
  logic [31:0] evtWrData = '0;
  logic [31:0] evtWord;
  logic        speedWrEn = 1'b0;
  logic [6:0]  speedWrData = '0;
  logic        mdc;
  logic        mdioOut;
  logic        mdioOe;
  logic        mdioIn = 1'b1;

  int vecCnt = 0;
  int errCnt = 0;
  bit finished = 0;

  // PHY model state
  int          mIdx = 0;
  logic [31:0] mCmd = '0;
  bit          mRead = 0;
  logic [15:0] mPhyData = '0;
  bit          preBad = 0;
  bit          oeBad = 0;
  bit          perBad = 0;
  int          mHalf = 2;
  longint      clkCnt = 0;
  longint      lastRise = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) clkCnt = clkCnt + 1;

  mdio_mgmt_master dut_i (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .dataWord(dataWord), .evtWrEn(evtWrEn), .evtWrData(evtWrData),
    .evtWord(evtWord), .speedWrEn(speedWrEn), .speedWrData(speedWrData),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always @(posedge mdc) begin
    if (mIdx < 32) begin
      if (!(mdioOut && mdioOe)) preBad = 1;
    end else begin
      mCmd = {mCmd[30:0], mdioOut};
      if (mdioOe !== ((mRead && mIdx >= 46) ? 1'b0 : 1'b1)) oeBad = 1;
    end
    if (mIdx > 0 && (clkCnt - lastRise) != longint'(2 * mHalf)) perBad = 1;
    lastRise = clkCnt;
    mIdx = mIdx + 1;
  end

  always @(negedge mdc) begin
    if (mRead && mIdx == 47)                   mdioIn = 1'b0;
    else if (mRead && mIdx >= 48 && mIdx < 64) mdioIn = mPhyData[63 - mIdx];
    else                                       mdioIn = 1'b1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic evtWrite(input logic [31:0] d);
    @(negedge clk); evtWrEn = 1'b1; evtWrData = d;
    @(posedge clk);
    @(negedge clk); evtWrEn = 1'b0;
  endtask

  task automatic runFrame(input logic [31:0] cmd, input logic [15:0] phy,
                          input logic [6:0] speed, input bit sameClr,
                          input bit intrude);
    int h;
    int waitLeft;
    logic [31:0] expData;
    @(negedge clk); speedWrEn = 1'b1; speedWrData = speed;
    @(posedge clk);
    @(negedge clk); speedWrEn = 1'b0;
    h = int'({speed[6:1], 1'b0});
    if (h == 0) h = 2;
    mHalf = h; mIdx = 0; mCmd = '0; preBad = 0; oeBad = 0; perBad = 0;
    mRead = (cmd[29:28] == 2'b10); mPhyData = phy; mdioIn = 1'b1;
    expData = mRead ? {cmd[31:16], phy} : cmd;
    cmdWrEn = 1'b1; cmdWrData = cmd;
    @(posedge clk);                // accepting edge
    @(negedge clk); cmdWrEn = 1'b0;
    waitLeft = 128 * h - 1;
    if (intrude) begin
      repeat (10) @(posedge clk);
      @(negedge clk); cmdWrEn = 1'b1; cmdWrData = ~cmd;
      @(posedge clk);
      @(negedge clk); cmdWrEn = 1'b0;
      waitLeft = waitLeft - 11;
    end
    repeat (waitLeft) @(posedge clk);
    @(negedge clk);
    check("R7 event not early", evtWord, 32'h0);
    if (sameClr) begin evtWrEn = 1'b1; evtWrData = EVT_MASK; end
    @(posedge clk);                // completing edge
    @(negedge clk); evtWrEn = 1'b0;
    check(sameClr ? "R8 set wins over clear" : "R7 event set", evtWord, EVT_MASK);
    check("R2 preamble", 32'(preBad), 32'h0);
    check("R3 rising edge count", 32'(mIdx), 32'd64);
    if (mRead) check("R3 read command bits", {16'h0, mCmd[31:16]}, {16'h0, cmd[31:16]});
    else       check("R3 write command bits", mCmd, cmd);
    check(mRead ? "R5 release pattern" : "R6 drive pattern", 32'(oeBad), 32'h0);
    check("R4 mdc period", 32'(perBad), 32'h0);
    check(intrude ? "R9 data after ignored write" : (mRead ? "R5 read data" : "R6 write data"),
          dataWord, expData);
    check("R4 mdc idle low", 32'(mdc), 32'h0);
    evtWrite(~EVT_MASK);
    check("R8 zero bit no effect", evtWord, EVT_MASK);
    evtWrite(EVT_MASK);
    check("R8 clear", evtWord, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errCnt++;
      vecCnt++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 dataWord", dataWord, 32'h0);
    check("R1 evtWord", evtWord, 32'h0);
    check("R1 mdc/oe", {30'h0, mdc, mdioOe}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    // sweep every PHY address with reads at the fastest clock
    for (int a = 0; a < 32; a++) begin
      logic [31:0] c;
      c = 32'h6002_0000 | (32'(a) << 23) | (32'((a * 7 + 3) & 31) << 18);
      runFrame(c, 16'(a * 16'h0813) ^ 16'hA5C3, 7'd2, (a % 8) == 5, 1'b0);
    end
    // writes across divider settings, including the clamped ones
    for (int s = 0; s < 9; s++) begin
      logic [31:0] c;
      c = 32'h5002_0000 | (32'(s * 3) << 23) | (32'(s + 1) << 18) | 32'(s * 16'h1F3B);
      runFrame(c, 16'h0, 7'(s), s == 4, 1'b0);
    end
    // command writes injected while a frame runs
    runFrame(32'h6002_0000 | (32'd9 << 23) | (32'd2 << 18), 16'h3C5A, 7'd4, 1'b0, 1'b1);
    runFrame(32'h5002_0000 | (32'd17 << 23) | (32'd4 << 18) | 32'hBEEF, 16'h0, 7'd2, 1'b1, 1'b1);
    // opcode 2'b11 counts as a write
    runFrame(32'h7002_0000 | (32'd1 << 23) | 32'h1234, 16'hFFFF, 7'd3, 1'b0, 1'b0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule